// File: doc/BRIEF.md
# Receive Queue Acceptance Filter

This block decides whether an arriving frame header is wanted by the receive queue. It holds a small table of 32-bit filter words and, beside each word, a 32-bit mask word. A format input sets how each word is read. It can be one filter for a 29-bit identifier, two filters for 11-bit identifiers, or four filters that each look at one byte of the identifier. Identifier filters also compare the IDE and RTR flags of the frame.

Headers arrive on a valid/ready stream. Each accepted header gives one result on a second valid/ready stream. The result holds an accept flag and the number of the lowest filter that matched. The sender may hold `hdr_valid` high for as long as it likes. A header is taken only in a cycle where `hdr_ready` is high. A result stays on the outputs, unchanged, until the consumer raises `res_ready`. `hdr_ready` is high when no result is pending or when the pending result is being taken in that cycle. Table and mask words are loaded through a simple write strobe.

Top module: `rxf_filter_top`

## Requirements
- R1: After reset `res_valid` is 0 and `hdr_ready` is 1. All filter and mask words are zero, so the first header taken in the 29-bit format is accepted with index 0.
- R2: When `cfg_we` is 1 at a clock edge, `cfg_wdata` is stored in word `cfg_idx`. It goes into the filter table when `cfg_sel` is 0 and into the mask table when `cfg_sel` is 1. The new word applies to headers taken after that edge.
- R3: A mask bit of 0 makes the matching filter bit don't-care. A mask bit of 1 makes the filter bit take part in the comparison.
- R4: When `fmt` is 0 (29-bit format), word e is filter e, for filters 0 to N-1. Bit 31 is compared with RTR, bit 30 with IDE, and bits 28:0 with `hdr_id[28:0]`. Bit 29 is never compared.
- R5: When `fmt` is 1 (11-bit format), bits 31:16 of word e are filter 2e and bits 15:0 are filter 2e+1. In each half, bit 15 is compared with RTR, bit 14 with IDE, and bits 10:0 with `hdr_id[10:0]`. Bits 13:11 of each half are never compared. The mask word is split into halves in the same way.
- R6: When `fmt` is 2 (byte format), bits 31-8k down to 24-8k of word e are filter 4e+k, for k from 0 to 3. Each byte is compared with `hdr_id[28:21]` when IDE is 1, and with `hdr_id[10:3]` when IDE is 0. RTR and IDE are not compared.
- R7: When more than one filter matches, `res_index` is the lowest matching filter number.
- R8: When no filter matches, `res_accept` is 0 and `res_index` is 0. The value `fmt`=3 matches nothing.
- R9: The result of a header taken at a clock edge is on `res_valid`, `res_accept` and `res_index` right after that edge.
- R10: While `res_valid` is 1 and `res_ready` is 0, `hdr_ready` is 0 and the result does not change. When the result is taken and no new header arrives in that cycle, `res_valid` goes to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 2 | Format of the table words: 0 = 29-bit, 1 = 11-bit, 2 = byte, 3 = none |
| cfg_we | input | 1 | Write strobe for a table or mask word |
| cfg_sel | input | 1 | Write target: 0 = filter word, 1 = mask word |
| cfg_idx | input | $clog2(N_ENTRIES) | Number of the word to write |
| cfg_wdata | input | 32 | Value to write |
| hdr_valid | input | 1 | A header is present on the input |
| hdr_ready | output | 1 | The block can take a header |
| hdr_id | input | 29 | Frame identifier; an 11-bit identifier sits in bits 10:0 |
| hdr_ide | input | 1 | Extended-identifier flag of the frame |
| hdr_rtr | input | 1 | Remote-request flag of the frame |
| res_valid | output | 1 | A result is present |
| res_ready | input | 1 | The consumer takes the result |
| res_accept | output | 1 | At least one filter matched |
| res_index | output | $clog2(4*N_ENTRIES) | Lowest matching filter number |

## Verification
The result of a header taken at clock edge k is due right after edge k: one register sits between the header and the result. The bench drives every header at a falling edge and lets exactly one rising edge pass. It reads the result at the following falling edge, before any new input. For the back-pressure case the bench holds `res_ready` low for several edges and reads the outputs at each falling edge. It then raises `res_ready` and expects the queued header's result one edge later. Table writes are made one clean cycle before the headers that depend on them.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    FMT_EXT   = 2'd0,
    FMT_STD   = 2'd1,
    FMT_SLICE = 2'd2,
    FMT_NONE  = 2'd3
  } rxf_fmt_e;

  // Bits of a word that take part in a comparison.
  localparam logic [31:0] EXT_CARE = 32'hDFFF_FFFF;
  localparam logic [15:0] STD_CARE = 16'hC7FF;
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs #(
  parameter int N_ENTRIES = 8,
  localparam int EW = $clog2(N_ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic                          cfg_sel,
  input  logic [EW-1:0]                 cfg_idx,
  input  logic [31:0]                   cfg_wdata,
  output logic [N_ENTRIES-1:0][31:0]    tbl,
  output logic [N_ENTRIES-1:0][31:0]    msk
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl <= '0;
      msk <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) msk[cfg_idx] <= cfg_wdata;
      else         tbl[cfg_idx] <= cfg_wdata;
    end
  end

  // R2: a write to the filter table lands in the addressed word
  p_tbl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> tbl[$past(cfg_idx)] == $past(cfg_wdata));
  // R2: a write to the mask table lands in the addressed word
  p_msk_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel) |=> msk[$past(cfg_idx)] == $past(cfg_wdata));
endmodule

// File: rtl/rxf_match.sv
module rxf_match
  import rxf_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  localparam int NF = 4 * N_ENTRIES
) (
  input  logic [1:0]                    fmt,
  input  logic [N_ENTRIES-1:0][31:0]    tbl,
  input  logic [N_ENTRIES-1:0][31:0]    msk,
  input  logic [28:0]                   id,
  input  logic                          ide,
  input  logic                          rtr,
  output logic [NF-1:0]                 vec
);
  logic [N_ENTRIES-1:0]   ext_v;
  logic [2*N_ENTRIES-1:0] std_v;
  logic [NF-1:0]          slc_v;
  logic [31:0]            ext_key;
  logic [15:0]            std_key;
  logic [7:0]             slc_key;

  assign ext_key = {rtr, ide, 1'b0, id};
  assign std_key = {rtr, ide, 3'b000, id[10:0]};
  assign slc_key = ide ? id[28:21] : id[10:3];

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    assign ext_v[e] = (((tbl[e] ^ ext_key) & msk[e] & EXT_CARE) == 32'd0);

    for (genvar h = 0; h < 2; h++) begin : g_half
      localparam int HI = 31 - 16 * h;
      assign std_v[2*e+h] =
        (((tbl[e][HI -: 16] ^ std_key) & msk[e][HI -: 16] & STD_CARE) == 16'd0);
    end

    for (genvar k = 0; k < 4; k++) begin : g_byte
      localparam int HI = 31 - 8 * k;
      assign slc_v[4*e+k] =
        (((tbl[e][HI -: 8] ^ slc_key) & msk[e][HI -: 8]) == 8'd0);
    end
  end

  always_comb begin
    vec = '0;
    case (rxf_fmt_e'(fmt))
      FMT_EXT:   vec[N_ENTRIES-1:0]   = ext_v;
      FMT_STD:   vec[2*N_ENTRIES-1:0] = std_v;
      FMT_SLICE: vec                  = slc_v;
      default:   vec                  = '0;
    endcase
  end
endmodule

// File: rtl/rxf_prio.sv
module rxf_prio #(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |vec;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/rxf_filter_top.sv
module rxf_filter_top #(
  parameter int N_ENTRIES = 8,
  localparam int EW = $clog2(N_ENTRIES),
  localparam int NF = 4 * N_ENTRIES,
  localparam int IW = $clog2(NF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fmt,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [EW-1:0] cfg_idx,
  input  logic [31:0]   cfg_wdata,
  input  logic          hdr_valid,
  output logic          hdr_ready,
  input  logic [28:0]   hdr_id,
  input  logic          hdr_ide,
  input  logic          hdr_rtr,
  output logic          res_valid,
  input  logic          res_ready,
  output logic          res_accept,
  output logic [IW-1:0] res_index
);
  logic [N_ENTRIES-1:0][31:0] tbl;
  logic [N_ENTRIES-1:0][31:0] msk;
  logic [NF-1:0]              match_vec;
  logic                       hit;
  logic [IW-1:0]              hit_idx;
  logic                       take;

  rxf_regs #(.N_ENTRIES(N_ENTRIES)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .tbl(tbl), .msk(msk)
  );

  rxf_match #(.N_ENTRIES(N_ENTRIES)) u_match (
    .fmt(fmt), .tbl(tbl), .msk(msk), .id(hdr_id), .ide(hdr_ide),
    .rtr(hdr_rtr), .vec(match_vec)
  );

  rxf_prio #(.W(NF)) u_prio (
    .vec(match_vec), .hit(hit), .idx(hit_idx)
  );

  assign hdr_ready = !res_valid || res_ready;
  assign take      = hdr_valid && hdr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_index  <= '0;
    end else if (take) begin
      res_valid  <= 1'b1;
      res_accept <= hit;
      res_index  <= hit ? hit_idx : '0;
    end else if (res_ready) begin
      res_valid  <= 1'b0;
    end
  end

  // R9: a taken header yields a result right after the edge
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> res_valid);
  // R10: a stalled result stays put
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_accept) && $stable(res_index)));
  // R10: a consumed result with no new header goes away
  p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !hdr_valid) |=> !res_valid);
  // R7: the reported filter matched and no lower one did
  p_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (match_vec[hit_idx] &&
             ((match_vec & ((NF'(1) << hit_idx) - NF'(1))) == '0)));
  // R4: the 29-bit format uses only the first N filter numbers
  p_ext_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == 2'd0) |-> (match_vec[NF-1:N_ENTRIES] == '0));
  // R8: the unused format value matches nothing
  p_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == 2'd3) |-> (match_vec == '0));
  // R8: a rejected result carries index 0
  p_reject_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_accept) |-> (res_index == '0));
endmodule

// File: tb/rxf_filter_top_test.sv
module rxf_filter_top_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [28:0] hdr_id = '0;
  logic        hdr_ide = 1'b0;
  logic        hdr_rtr = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_accept;
  logic [4:0]  res_index;

  int checks = 0;
  int errors = 0;
  logic [31:0] sh_tab [N];
  logic [31:0] sh_msk [N];
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  rxf_filter_top #(.N_ENTRIES(N)) uut (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .hdr_valid(hdr_valid),
    .hdr_ready(hdr_ready), .hdr_id(hdr_id), .hdr_ide(hdr_ide),
    .hdr_rtr(hdr_rtr), .res_valid(res_valid), .res_ready(res_ready),
    .res_accept(res_accept), .res_index(res_index)
  );

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected result worked out from the word layouts of R4, R5, R6.
  task automatic model(input int fm, input logic [28:0] id, input logic ide,
                       input logic rtr, output int hit, output int idx);
    int nf;
    hit = 0;
    idx = 0;
    nf = (fm == 0) ? N : (fm == 1) ? 2 * N : (fm == 2) ? 4 * N : 0;
    for (int f = nf - 1; f >= 0; f--) begin
      logic ok;
      ok = 1'b0;
      if (fm == 0) begin
        logic [31:0] d;
        d = {rtr, ide, 1'b0, id};
        ok = (((sh_tab[f] ^ d) & sh_msk[f] & 32'hDFFF_FFFF) == 0);
      end else if (fm == 1) begin
        logic [15:0] w, m, d;
        w = 16'(sh_tab[f/2] >> (16 * (1 - f % 2)));
        m = 16'(sh_msk[f/2] >> (16 * (1 - f % 2)));
        d = {rtr, ide, 3'b000, id[10:0]};
        ok = (((w ^ d) & m & 16'hC7FF) == 0);
      end else begin
        logic [7:0] w, m, d;
        w = 8'(sh_tab[f/4] >> (8 * (3 - f % 4)));
        m = 8'(sh_msk[f/4] >> (8 * (3 - f % 4)));
        d = ide ? id[28:21] : id[10:3];
        ok = (((w ^ d) & m) == 0);
      end
      if (ok) begin
        hit = 1;
        idx = f;
      end
    end
  endtask

  task automatic wr(input logic sel, input int idx, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sel = sel;
    cfg_idx = 3'(idx);
    cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) sh_msk[idx] = data;
    else     sh_tab[idx] = data;
  endtask

  task automatic send(input logic [28:0] id, input logic ide, input logic rtr);
    @(negedge clk);
    hdr_valid = 1'b1;
    hdr_id = id;
    hdr_ide = ide;
    hdr_rtr = rtr;
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  task automatic send_check(input string tag, input int fm, input logic [28:0] id,
                            input logic ide, input logic rtr);
    int eh, ei;
    model(fm, id, ide, rtr, eh, ei);
    send(id, ide, rtr);
    chk({tag, " R9 valid"}, int'(res_valid), 1);
    chk({tag, " accept"}, int'(res_accept), eh);
    chk({tag, " index"}, int'(res_index), ei);
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      sh_tab[i] = '0;
      sh_msk[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 res_valid", int'(res_valid), 0);
    chk("R1 hdr_ready", int'(hdr_ready), 1);
    fmt = 2'd0;
    send_check("R1 zero masks", 0, 29'h155_AAAA, 1'b1, 1'b0);
    chk("R1 index zero", int'(res_index), 0);

    // R2 R3: a fully masked word must match exactly; bit 29 is ignored (R4)
    wr(1'b0, 0, 32'hE000_0123);
    wr(1'b1, 0, 32'hFFFF_FFFF);
    send_check("R4 bit29 ignored", 0, 29'h0000_0123, 1'b1, 1'b1);
    send_check("R3 exact miss", 0, 29'h0000_0122, 1'b1, 1'b1);
    send_check("R4 rtr miss", 0, 29'h0000_0123, 1'b1, 1'b0);
    wr(1'b1, 0, 32'hFFFF_FFFE);
    send_check("R2 R3 mask rewrite", 0, 29'h0000_0122, 1'b1, 1'b1);

    // R7: filters 2 and 5 match, the others do not
    for (int i = 0; i < N; i++) begin
      wr(1'b0, i, (i == 2 || i == 5) ? 32'h4000_0777 : 32'h4000_0000 | 32'(i));
      wr(1'b1, i, 32'hFFFF_FFFF);
    end
    send_check("R7 lowest", 0, 29'h0000_0777, 1'b1, 1'b0);
    chk("R7 index two", int'(res_index), 2);
    send_check("R8 no match", 0, 29'h1FFF_FFFF, 1'b0, 1'b0);
    chk("R8 reject", int'(res_accept), 0);
    fmt = 2'd3;
    send_check("R8 fmt3", 3, 29'h0000_0777, 1'b1, 1'b0);
    chk("R8 fmt3 reject", int'(res_accept), 0);

    // R10: back-pressure
    fmt = 2'd0;
    @(negedge clk);
    hdr_valid = 1'b1;
    hdr_id = 29'h0000_0777;
    hdr_ide = 1'b1;
    hdr_rtr = 1'b0;
    res_ready = 1'b0;
    @(negedge clk);
    hdr_id = 29'h0000_0003;
    for (int c = 0; c < 3; c++) begin
      chk("R10 held valid", int'(res_valid), 1);
      chk("R10 ready low", int'(hdr_ready), 0);
      chk("R10 held index", int'(res_index), 2);
      @(negedge clk);
    end
    res_ready = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    chk("R10 next result", int'(res_index), 3);
    chk("R10 next valid", int'(res_valid), 1);
    @(negedge clk);
    chk("R10 drop", int'(res_valid), 0);

    // Sweeps over each format with random words and near-miss headers.
    for (int fm = 0; fm < 3; fm++) begin
      string tag;
      tag = (fm == 0) ? "R4 R3" : (fm == 1) ? "R5 R3" : "R6 R3";
      for (int i = 0; i < N; i++) begin
        wr(1'b0, i, rnd());
        wr(1'b1, i, rnd() | rnd() | rnd());
      end
      @(negedge clk);
      fmt = 2'(fm);
      for (int t = 0; t < 160; t++) begin
        logic [31:0] r, nz;
        logic [28:0] id;
        logic ide, rtr;
        int f;
        r = rnd();
        nz = rnd();
        id = rnd()[28:0];
        ide = r[30];
        rtr = r[31];
        if (fm == 0) begin
          f = int'(r[2:0]);
          id = sh_tab[f][28:0];
          ide = sh_tab[f][30];
          rtr = sh_tab[f][31];
        end else if (fm == 1) begin
          logic [15:0] hw;
          f = int'(r[3:0]);
          hw = 16'(sh_tab[f/2] >> (16 * (1 - f % 2)));
          id[10:0] = hw[10:0];
          ide = hw[14];
          rtr = hw[15];
        end else begin
          logic [7:0] b;
          f = int'(r[4:0]);
          b = 8'(sh_tab[f/4] >> (8 * (3 - f % 4)));
          if (ide) id[28:21] = b;
          else     id[10:3] = b;
        end
        if (nz[0]) id = id ^ (29'd1 << (nz[15:8] % 29));
        if (nz[1]) ide = ~ide;
        if (nz[2]) rtr = ~rtr;
        send_check(tag, fm, id, ide, rtr);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule